// File: doc/BRIEF.md
# Split Read/Write Memory Bank Mapper

This block turns a 16-bit offset inside a 64 KB host memory window into a linear video memory address. It makes one address for CPU reads and one for CPU writes. Each direction has its own 64 KB bank number. A split-enable input decides whether reads use their own bank. When split mode is off, reads use the write bank, so both directions see the same window.

Each address is the bank base plus the window offset. The result is then trimmed to the installed memory size, which a strap input selects: 256 KB, 512 KB or 1 MB. Both addresses are registered and come with a valid strobe one cycle after the request. The block also drives the address mask used by display fetch. That mask covers all installed memory only when the extended registers are unlocked and the wide-display bit is set. Otherwise it covers 256 KB.

Top module: `vmem_bank_mapper`

## Requirements
- R1: One cycle after `wr_req_i`, `wr_addr_o` equals (`wr_bank_reg_i[3:0]` * 65536 + `ofs_i`) ANDed with the installed-memory mask. Bits 7:4 of the bank register have no effect.
- R2: With `split_en_i` = 1, the read address captured on `rd_req_i` uses `rd_bank_reg_i[3:0]` * 65536 as its base, with the same offset and masking as R1.
- R3: With `split_en_i` = 0, the read address uses the write bank `wr_bank_reg_i[3:0]`, and `rd_bank_reg_i` has no effect.
- R4: The installed-memory mask is chosen by `mem_size_i`: 2'b00 gives 0x3FFFF (256 KB), 2'b01 gives 0x7FFFF (512 KB), and 2'b10 or 2'b11 give 0xFFFFF (1 MB). Captured addresses never have bits set outside this mask.
- R5: `rd_valid_o` and `wr_valid_o` are high for exactly the cycles that follow a cycle with `rd_req_i` or `wr_req_i` high, respectively. The two directions are independent.
- R6: While no request is made in a direction, that direction's address output holds its last value, even if the bank, offset or split inputs change.
- R7: A bank or split change applied in the same cycle as a request is used by that request.
- R8: `disp_mask_o` equals the installed-memory mask when both `ext_unlock_i` and `disp_wide_i` are 1. Otherwise it is 0x3FFFF.
- R9: During and right after reset, both addresses are 0 and both valid strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_size_i | input | 2 | Installed memory size select (00 = 256 KB, 01 = 512 KB, 1x = 1 MB) |
| rd_bank_reg_i | input | 8 | Read bank register value |
| wr_bank_reg_i | input | 8 | Write bank register value |
| split_en_i | input | 1 | 1: reads use the read bank; 0: reads use the write bank |
| ext_unlock_i | input | 1 | Extended register unlock |
| disp_wide_i | input | 1 | Display fetch covers all installed memory |
| rd_req_i | input | 1 | Host read request |
| wr_req_i | input | 1 | Host write request |
| ofs_i | input | 16 | Offset inside the 64 KB host window |
| rd_addr_o | output | 20 | Registered read address |
| rd_valid_o | output | 1 | Read address valid strobe |
| wr_addr_o | output | 20 | Registered write address |
| wr_valid_o | output | 1 | Write address valid strobe |
| disp_mask_o | output | 20 | Display fetch address mask |

## Verification
The bench builds the block with its default parameters: 4 bank bits, a 16-bit offset, 8-bit bank registers and a 256 KB base size, which gives 20-bit addresses. Because memory size is a strap input rather than a parameter, a single build reaches all three sizes. This lets the bench check that high banks wrap onto lower memory at 256 KB and 512 KB and run through unchanged at 1 MB. The 8-bit bank registers leave the upper nibble free, so the bench can show that those bits are ignored.

// File: rtl/vmem_bank_pkg.sv
package vmem_bank_pkg;
  typedef enum logic [1:0] {
    MEM_256K = 2'b00,
    MEM_512K = 2'b01,
    MEM_1M   = 2'b10,
    MEM_1M_A = 2'b11
  } mem_size_e;

  localparam int NUM_PORTS = 2;
  localparam int PORT_RD   = 0;
  localparam int PORT_WR   = 1;
endpackage

// File: rtl/vmem_size_mask.sv
module vmem_size_mask
  import vmem_bank_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int BASE_LOG2 = 18
) (
  input  mem_size_e         size_i,
  input  logic              ext_unlock_i,
  input  logic              disp_wide_i,
  output logic [ADDR_W-1:0] mem_mask_o,
  output logic [ADDR_W-1:0] disp_mask_o
);
  localparam logic [ADDR_W-1:0] ONES      = '1;
  localparam logic [ADDR_W-1:0] BASE_MASK = ~(ONES << BASE_LOG2);

  int unsigned shift;

  always_comb begin
    unique case (size_i)
      MEM_256K: shift = BASE_LOG2;
      MEM_512K: shift = BASE_LOG2 + 1;
      default:  shift = BASE_LOG2 + 2;
    endcase
    mem_mask_o  = ~(ONES << shift);
    disp_mask_o = (ext_unlock_i && disp_wide_i) ? mem_mask_o : BASE_MASK;
  end
endmodule

// File: rtl/vmem_bank_sel.sv
module vmem_bank_sel #(
  parameter int BANK_W = 4
) (
  input  logic [BANK_W-1:0] rd_bank_i,
  input  logic [BANK_W-1:0] wr_bank_i,
  input  logic              split_en_i,
  output logic [BANK_W-1:0] rd_sel_o,
  output logic [BANK_W-1:0] wr_sel_o
);
  assign wr_sel_o = wr_bank_i;
  assign rd_sel_o = split_en_i ? rd_bank_i : wr_bank_i;
endmodule

// File: rtl/vmem_addr_compose.sv
module vmem_addr_compose #(
  parameter int BANK_W = 4,
  parameter int OFS_W  = 16,
  parameter int ADDR_W = BANK_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [ADDR_W-1:0] mask_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o
);
  logic [ADDR_W-1:0] base, lin;

  assign base = ADDR_W'({bank_i, {OFS_W{1'b0}}});
  assign lin  = (base + ADDR_W'(ofs_i)) & mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= req_i;
      if (req_i) addr_o <= lin;
    end
  end

  // R5
  p_valid_follows_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  p_no_spurious_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  // R4
  p_addr_in_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ((addr_o & ~$past(mask_i)) == '0));
  // R6
  p_addr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(addr_o));
endmodule

// File: rtl/vmem_bank_mapper.sv
module vmem_bank_mapper
  import vmem_bank_pkg::*;
#(
  parameter int REG_W     = 8,
  parameter int BANK_W    = 4,
  parameter int OFS_W     = 16,
  parameter int BASE_LOG2 = 18,
  localparam int ADDR_W   = BANK_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mem_size_i,
  input  logic [REG_W-1:0]  rd_bank_reg_i,
  input  logic [REG_W-1:0]  wr_bank_reg_i,
  input  logic              split_en_i,
  input  logic              ext_unlock_i,
  input  logic              disp_wide_i,
  input  logic              rd_req_i,
  input  logic              wr_req_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] disp_mask_o
);
  localparam logic [ADDR_W-1:0] BASE_MASK = ~({ADDR_W{1'b1}} << BASE_LOG2);

  logic [ADDR_W-1:0] mem_mask;
  logic [BANK_W-1:0] sel_bank [NUM_PORTS];
  logic              req      [NUM_PORTS];
  logic [ADDR_W-1:0] addr     [NUM_PORTS];
  logic              valid    [NUM_PORTS];
  logic              bank_hi_unused;

  assign bank_hi_unused = ^{rd_bank_reg_i[REG_W-1:BANK_W], wr_bank_reg_i[REG_W-1:BANK_W]};

  vmem_size_mask #(.ADDR_W(ADDR_W), .BASE_LOG2(BASE_LOG2)) u_mask (
    .size_i       (mem_size_e'(mem_size_i)),
    .ext_unlock_i (ext_unlock_i),
    .disp_wide_i  (disp_wide_i),
    .mem_mask_o   (mem_mask),
    .disp_mask_o  (disp_mask_o)
  );

  vmem_bank_sel #(.BANK_W(BANK_W)) u_sel (
    .rd_bank_i  (rd_bank_reg_i[BANK_W-1:0]),
    .wr_bank_i  (wr_bank_reg_i[BANK_W-1:0]),
    .split_en_i (split_en_i),
    .rd_sel_o   (sel_bank[PORT_RD]),
    .wr_sel_o   (sel_bank[PORT_WR])
  );

  assign req[PORT_RD] = rd_req_i;
  assign req[PORT_WR] = wr_req_i;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    vmem_addr_compose #(.BANK_W(BANK_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_comp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req[g]),
      .bank_i  (sel_bank[g]),
      .ofs_i   (ofs_i),
      .mask_i  (mem_mask),
      .addr_o  (addr[g]),
      .valid_o (valid[g])
    );
  end

  assign rd_addr_o  = addr[PORT_RD];
  assign rd_valid_o = valid[PORT_RD];
  assign wr_addr_o  = addr[PORT_WR];
  assign wr_valid_o = valid[PORT_WR];

  // R3: unsplit simultaneous access lands on one address
  p_unsplit_same_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && wr_req_i && !split_en_i) |=> (rd_addr_o == wr_addr_o));
  // R8
  p_disp_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ext_unlock_i && disp_wide_i) |-> (disp_mask_o == BASE_MASK));
  // R8: display mask never exceeds installed memory
  p_disp_within_mem_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((disp_mask_o & ~mem_mask) == '0) || (disp_mask_o == BASE_MASK));
  // R9
  always_comb begin
    if (!rst_ni) begin
      a_reset_idle_r9: assert (!rd_valid_o && !wr_valid_o && rd_addr_o == '0 && wr_addr_o == '0);
    end
  end
endmodule

// File: tb/tb_vmem_bank_mapper.sv
module tb_vmem_bank_mapper;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mem_size_i = 2'b10;
  logic [7:0]  rd_bank_reg_i = '0;
  logic [7:0]  wr_bank_reg_i = '0;
  logic        split_en_i = 1'b0;
  logic        ext_unlock_i = 1'b0;
  logic        disp_wide_i = 1'b0;
  logic        rd_req_i = 1'b0;
  logic        wr_req_i = 1'b0;
  logic [15:0] ofs_i = '0;
  logic [19:0] rd_addr_o, wr_addr_o, disp_mask_o;
  logic        rd_valid_o, wr_valid_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  vmem_bank_mapper dut (.*);

  function automatic logic [19:0] size_mask(input logic [1:0] s);
    longint bytes;
    bytes = (s == 2'b00) ? 262144 : (s == 2'b01) ? 524288 : 1048576;
    return 20'(bytes - 1);
  endfunction

  function automatic logic [19:0] expect_addr(input logic [7:0] bank, input logic [15:0] o,
                                              input logic [1:0] s);
    longint lin, bytes;
    bytes = (s == 2'b00) ? 262144 : (s == 2'b01) ? 524288 : 1048576;
    lin   = longint'(bank % 16) * 65536 + longint'(o);
    return 20'(lin % bytes);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive on negedge, capture at posedge, sample 1 ns later
  task automatic access(input logic rd, input logic wr, input logic [15:0] o);
    @(negedge clk_i);
    rd_req_i = rd; wr_req_i = wr; ofs_i = o;
    @(posedge clk_i); #1;
    @(negedge clk_i);
    rd_req_i = 1'b0; wr_req_i = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    check("R9 rd_valid in reset", 32'(rd_valid_o), 0);
    check("R9 wr_addr in reset", 32'(wr_addr_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R9 rd_addr after reset", 32'(rd_addr_o), 0);
    check("R9 wr_valid after reset", 32'(wr_valid_o), 0);
  endtask

  task automatic t_write_basic;
    mem_size_i = 2'b10; wr_bank_reg_i = 8'hA3;
    access(1'b0, 1'b1, 16'h4321);
    check("R1 write addr upper nibble ignored", 32'(wr_addr_o), 32'(expect_addr(8'h03, 16'h4321, 2'b10)));
    wr_bank_reg_i = 8'h0F;
    access(1'b0, 1'b1, 16'hFFFF);
    check("R1 write addr top of 1MB", 32'(wr_addr_o), 32'h000FFFFF);
  endtask

  task automatic t_split_on;
    split_en_i = 1'b1; rd_bank_reg_i = 8'h57; wr_bank_reg_i = 8'h02;
    access(1'b1, 1'b1, 16'h0100);
    check("R2 split read bank", 32'(rd_addr_o), 32'(expect_addr(8'h57, 16'h0100, 2'b10)));
    check("R2 split write unaffected", 32'(wr_addr_o), 32'(expect_addr(8'h02, 16'h0100, 2'b10)));
  endtask

  task automatic t_split_off;
    split_en_i = 1'b0; rd_bank_reg_i = 8'h09; wr_bank_reg_i = 8'h05;
    access(1'b1, 1'b0, 16'h0ABC);
    check("R3 unsplit read uses write bank", 32'(rd_addr_o), 32'(expect_addr(8'h05, 16'h0ABC, 2'b10)));
    rd_bank_reg_i = 8'h0E;
    access(1'b1, 1'b1, 16'h0011);
    check("R3 rd bank ignored", 32'(rd_addr_o), 32'(wr_addr_o));
  endtask

  task automatic t_sizes;
    wr_bank_reg_i = 8'h0D;
    for (int s = 0; s < 4; s++) begin
      mem_size_i = 2'(s);
      access(1'b0, 1'b1, 16'h1234);
      check($sformatf("R4 size %0d wrap", s), 32'(wr_addr_o), 32'(expect_addr(8'h0D, 16'h1234, 2'(s))));
    end
    mem_size_i = 2'b00;
    access(1'b0, 1'b1, 16'h1234);
    check("R4 256K bits clear", 32'(wr_addr_o & ~size_mask(2'b00)), 0);
    mem_size_i = 2'b10;
  endtask

  task automatic t_strobes;
    @(negedge clk_i); rd_req_i = 1'b1; wr_req_i = 1'b0;
    @(posedge clk_i); #1;
    check("R5 rd strobe", 32'(rd_valid_o), 1);
    check("R5 wr strobe independent", 32'(wr_valid_o), 0);
    @(negedge clk_i); rd_req_i = 1'b0; wr_req_i = 1'b1;
    @(posedge clk_i); #1;
    check("R5 rd strobe drops", 32'(rd_valid_o), 0);
    check("R5 wr strobe", 32'(wr_valid_o), 1);
    @(negedge clk_i); wr_req_i = 1'b0;
    @(posedge clk_i); #1;
    check("R5 wr strobe one cycle", 32'(wr_valid_o), 0);
  endtask

  task automatic t_hold;
    logic [19:0] rd_keep, wr_keep;
    split_en_i = 1'b1; rd_bank_reg_i = 8'h01; wr_bank_reg_i = 8'h02;
    access(1'b1, 1'b1, 16'h0055);
    rd_keep = rd_addr_o; wr_keep = wr_addr_o;
    @(negedge clk_i);
    rd_bank_reg_i = 8'h0C; wr_bank_reg_i = 8'h0B; ofs_i = 16'hBEEF; split_en_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    check("R6 read addr held", 32'(rd_addr_o), 32'(rd_keep));
    check("R6 write addr held", 32'(wr_addr_o), 32'(wr_keep));
  endtask

  task automatic t_same_cycle;
    @(negedge clk_i);
    split_en_i = 1'b1; rd_bank_reg_i = 8'h07; wr_bank_reg_i = 8'h08;
    rd_req_i = 1'b1; wr_req_i = 1'b1; ofs_i = 16'h0F00;
    @(posedge clk_i); #1;
    check("R7 new read bank used", 32'(rd_addr_o), 32'(expect_addr(8'h07, 16'h0F00, 2'b10)));
    check("R7 new write bank used", 32'(wr_addr_o), 32'(expect_addr(8'h08, 16'h0F00, 2'b10)));
    @(negedge clk_i);
    split_en_i = 1'b0;
    @(posedge clk_i); #1;
    check("R7 split drop used at once", 32'(rd_addr_o), 32'(expect_addr(8'h08, 16'h0F00, 2'b10)));
    @(negedge clk_i); rd_req_i = 1'b0; wr_req_i = 1'b0;
  endtask

  task automatic t_disp;
    for (int s = 0; s < 3; s++) begin
      mem_size_i = 2'(s);
      ext_unlock_i = 1'b1; disp_wide_i = 1'b1; #1;
      check($sformatf("R8 wide mask size %0d", s), 32'(disp_mask_o), 32'(size_mask(2'(s))));
      disp_wide_i = 1'b0; #1;
      check("R8 narrow mask", 32'(disp_mask_o), 32'h0003FFFF);
      ext_unlock_i = 1'b0; disp_wide_i = 1'b1; #1;
      check("R8 locked mask", 32'(disp_mask_o), 32'h0003FFFF);
    end
    mem_size_i = 2'b10;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset;
    t_write_basic;
    t_split_on;
    t_split_off;
    t_sizes;
    t_strobes;
    t_hold;
    t_same_cycle;
    t_disp;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule